// File: doc/BRIEF.md
# Dual-Master Downstream Bus Arbiter

This block decides which of two upstream controllers may drive a single shared downstream serial bus. Each controller raises a request, later drops ownership with a release pulse, and supplies its own reserve length. The reserve length is counted in ticks derived from the clock by a prescaler. The block answers with a one-hot grant, a connect enable for the downstream path, and one-cycle pulses that report when a controller gains or loses ownership.

A request that arrives while the other side owns the bus is kept pending. It is served when the owner releases the bus, or when the owner's reserve window has run out. While the window runs, nothing the other controller does can take the bus away. An optional idle watchdog watches a downstream activity strobe. When the strobe stays quiet for the configured time, the watchdog drops the owner and every pending request. A chip reset, an active-low external reset or a software reset pulse all return the block to its power-on state with nobody connected.

Top module: `dmb_arbiter`

## Requirements
- R1: When the bus is unowned and both request bits (bit 0 = controller 0, bit 1 = controller 1) are seen in the same cycle, controller 0 gets the grant (grant = 01) in the next cycle. Controller 1's request stays pending.
- R2: A request seen while the other controller owns the bus is held. After the owner's release pulse, grant is 00 for exactly one cycle and then goes to the waiting controller.
- R3: A nonzero reserve value N loaded at grant time keeps the grant with the owner for N×CLK_HZ/TICK_HZ cycles after the grant edge, regardless of the other controller's requests.
- R4: When the window has run out and the other controller is pending, the owner's grant drops with a one-cycle lost pulse on its bit. The waiting controller is granted one cycle later, with a one-cycle gained pulse.
- R5: A reserve value of zero gives no window. The owner keeps the bus until it releases it, no matter how long the other controller waits.
- R6: With the watchdog enabled, IDLE_TICKS×CLK_HZ/TICK_HZ quiet cycles while owned remove grant and connect, pulse lost for the owner, and clear all pending requests. This happens even during a reserve window.
- R7: Every activity strobe restarts the quiet count, so the disconnect comes that many cycles after the last strobe.
- R8: The chip reset, a low ext_rst_n or a soft_rst pulse clears ownership and pending requests in the next cycle, without gained or lost pulses. After reset, grant, connect and both pulse outputs are zero.
- R9: At most one grant bit is ever high, and connect is high exactly when a grant bit is high.
- R10: gained pulses for one cycle on the new owner's bit when ownership starts. A release by the owner produces no lost pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high chip reset |
| ext_rst_n | input | 1 | Active-low external reset, sampled on the clock |
| soft_rst | input | 1 | Software reset command pulse |
| req | input | 2 | Request pulses, bit per controller |
| rel | input | 2 | Release pulses, bit per controller; also cancels a pending request |
| resv0 | input | RESV_W | Reserve length in ticks for controller 0 |
| resv1 | input | RESV_W | Reserve length in ticks for controller 1 |
| wd_en | input | 1 | Idle watchdog enable |
| bus_act | input | 1 | Downstream edge-activity strobe |
| grant | output | 2 | One-hot ownership |
| connect | output | 1 | Downstream path enable |
| gained | output | 2 | One-cycle pulse when a controller becomes owner |
| lost | output | 2 | One-cycle pulse when ownership is taken from a controller |

## Verification
The hardest case is a watchdog disconnect that lands inside a long reserve window while the other controller is queued. It takes a protected owner, a pending request that must not be served, and hundreds of quiet cycles after a strobe that restarted the count. The bench reaches it with a small tick divider and a large reserve value for controller 1. It spaces several activity strobes, raises controller 0's request mid-window, and then confirms that the timeout removes the owner and leaves the queued request dropped. Handover on expiry is reached the same way, with a short reserve and a request placed just after the grant.

// File: rtl/dmb_pkg.sv
package dmb_pkg;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_OWN  = 1'b1
    } arb_state_e;

    typedef struct packed {
        arb_state_e st;
        logic       who;
    } own_s;

    // Fixed priority: controller 0 wins a tie.
    function automatic logic pick_winner(input logic [1:0] pend);
        return pend[0] ? 1'b0 : 1'b1;
    endfunction

    function automatic logic [1:0] side_mask(input logic who);
        return who ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/dmb_tick_gen.sv
module dmb_tick_gen #(
    parameter int CYC_PER_TICK = 8
) (
    input  logic clk,
    input  logic clr,
    input  logic restart,
    output logic tick
);
    localparam int CW = (CYC_PER_TICK > 1) ? $clog2(CYC_PER_TICK) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_TICK - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr || restart)   cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    generate
        if (CYC_PER_TICK > 1) begin : g_spacing
            assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (clr)
                (tick && !restart) |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/dmb_reserve_timer.sv
module dmb_reserve_timer #(
    parameter int RESV_W = 8
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              load,
    input  logic [RESV_W-1:0] value,
    input  logic              tick,
    output logic              active,
    output logic              expired
);
    logic [RESV_W-1:0] rcnt;
    logic              prot;

    always_ff @(posedge clk) begin
        if (clr) begin
            rcnt <= '0;
            prot <= 1'b0;
        end else if (load) begin
            rcnt <= value;
            prot <= (value != '0);
        end else if (tick && rcnt != '0) begin
            rcnt <= rcnt - 1'b1;
        end
    end

    assign active  = (rcnt != '0);
    assign expired = prot && (rcnt == '0);

    // A fresh window never reports expiry straight away (R5, R3).
    assert_fresh_load_R5: assert property (@(posedge clk) disable iff (clr)
        load |=> !expired);

endmodule

// File: rtl/dmb_idle_watchdog.sv
module dmb_idle_watchdog #(
    parameter int LIMIT = 800
) (
    input  logic clk,
    input  logic clr,
    input  logic enable,
    input  logic armed,
    input  logic activity,
    output logic timeout
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] icnt;

    always_ff @(posedge clk) begin
        if (clr || !armed || !enable || activity) icnt <= '0;
        else if (icnt != TOP)                     icnt <= icnt + 1'b1;
    end

    assign timeout = enable && armed && (icnt == TOP);

    assert_activity_restart_R7: assert property (@(posedge clk) disable iff (clr)
        activity |=> !timeout);

endmodule

// File: rtl/dmb_arbiter.sv
module dmb_arbiter
    import dmb_pkg::*;
#(
    parameter int CLK_HZ     = 200_000_000,
    parameter int TICK_HZ    = 1000,
    parameter int IDLE_TICKS = 100,
    parameter int RESV_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_rst_n,
    input  logic              soft_rst,
    input  logic [1:0]        req,
    input  logic [1:0]        rel,
    input  logic [RESV_W-1:0] resv0,
    input  logic [RESV_W-1:0] resv1,
    input  logic              wd_en,
    input  logic              bus_act,
    output logic [1:0]        grant,
    output logic              connect,
    output logic [1:0]        gained,
    output logic [1:0]        lost
);
    localparam int CYC_PER_TICK = CLK_HZ / TICK_HZ;
    localparam int IDLE_CYC     = CYC_PER_TICK * IDLE_TICKS;

    logic clr;
    assign clr = rst || !ext_rst_n || soft_rst;

    own_s              own_q, own_n;
    logic [1:0]        pend_q, pend_n;
    logic [1:0]        gain_q, gain_n;
    logic [1:0]        lost_q, lost_n;
    logic              load;
    logic              win;
    logic [RESV_W-1:0] load_val;
    logic              tick, rsv_active, rsv_expired, wd_timeout;
    logic              owning;

    assign owning = (own_q.st == ARB_OWN);

    dmb_tick_gen #(.CYC_PER_TICK(CYC_PER_TICK)) u_tick (
        .clk(clk), .clr(clr), .restart(load), .tick(tick)
    );

    dmb_reserve_timer #(.RESV_W(RESV_W)) u_resv (
        .clk(clk), .clr(clr), .load(load), .value(load_val), .tick(tick),
        .active(rsv_active), .expired(rsv_expired)
    );

    dmb_idle_watchdog #(.LIMIT(IDLE_CYC)) u_wd (
        .clk(clk), .clr(clr), .enable(wd_en), .armed(owning),
        .activity(bus_act), .timeout(wd_timeout)
    );

    always_comb begin
        own_n    = own_q;
        pend_n   = (pend_q | req) & ~rel;
        gain_n   = 2'b00;
        lost_n   = 2'b00;
        load     = 1'b0;
        win      = pick_winner(pend_n);
        load_val = win ? resv1 : resv0;
        case (own_q.st)
            ARB_IDLE: begin
                if (pend_n != 2'b00) begin
                    own_n.st    = ARB_OWN;
                    own_n.who   = win;
                    load        = 1'b1;
                    gain_n      = side_mask(win);
                    pend_n[win] = 1'b0;
                end
            end
            ARB_OWN: begin
                pend_n[own_q.who] = 1'b0;
                if (wd_timeout) begin
                    own_n.st = ARB_IDLE;
                    lost_n   = side_mask(own_q.who);
                    pend_n   = 2'b00;
                end else if (rel[own_q.who]) begin
                    own_n.st = ARB_IDLE;
                end else if (rsv_expired && pend_n[~own_q.who]) begin
                    own_n.st = ARB_IDLE;
                    lost_n   = side_mask(own_q.who);
                end
            end
            default: own_n.st = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            own_q  <= '{st: ARB_IDLE, who: 1'b0};
            pend_q <= 2'b00;
            gain_q <= 2'b00;
            lost_q <= 2'b00;
        end else begin
            own_q  <= own_n;
            pend_q <= pend_n;
            gain_q <= gain_n;
            lost_q <= lost_n;
        end
    end

    assign connect = owning;
    assign grant   = owning ? side_mask(own_q.who) : 2'b00;
    assign gained  = gain_q;
    assign lost    = lost_q;

    assert_no_direct_swap_0_R2: assert property (@(posedge clk) disable iff (clr)
        grant[0] |=> !grant[1]);
    assert_no_direct_swap_1_R2: assert property (@(posedge clk) disable iff (clr)
        grant[1] |=> !grant[0]);
    assert_window_holds_R3: assert property (@(posedge clk) disable iff (clr)
        (connect && rsv_active && !wd_timeout && !rel[own_q.who]) |=> (grant == $past(grant)));
    assert_loss_disconnects_R4: assert property (@(posedge clk) disable iff (clr)
        (lost != 2'b00) |-> !connect);
    assert_single_owner_R9: assert property (@(posedge clk) disable iff (clr)
        $onehot0(grant) && (connect == (grant != 2'b00)));
    assert_gain_on_connect_R10: assert property (@(posedge clk) disable iff (clr)
        $rose(connect) |-> $onehot(gained));

endmodule

// File: tb/test_dmb_arbiter.sv
module test_dmb_arbiter;

    localparam int RW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ext_rst_n = 1'b1;
    logic          soft_rst = 1'b0;
    logic [1:0]    req = 2'b00;
    logic [1:0]    rel = 2'b00;
    logic [RW-1:0] resv0 = '0;
    logic [RW-1:0] resv1 = 8'd3;
    logic          wd_en = 1'b0;
    logic          bus_act = 1'b0;
    logic [1:0]    grant, gained, lost;
    logic          connect;

    always #2.5 clk = ~clk;

    // 8 cycles per tick, 800 quiet cycles to time out
    dmb_arbiter #(.CLK_HZ(8000), .TICK_HZ(1000), .IDLE_TICKS(100), .RESV_W(RW)) i_dmb_arbiter (
        .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .soft_rst(soft_rst),
        .req(req), .rel(rel), .resv0(resv0), .resv1(resv1),
        .wd_en(wd_en), .bus_act(bus_act),
        .grant(grant), .connect(connect), .gained(gained), .lost(lost)
    );

    typedef struct {
        int         at;
        logic [1:0] g;
        logic       c;
        logic [1:0] ga;
        logic [1:0] lo;
        string      tag;
    } exp_t;

    exp_t q[$];
    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input int at, input logic [1:0] g, input logic c,
                        input logic [1:0] ga, input logic [1:0] lo, input string tag);
        exp_t e;
        e.at = at; e.g = g; e.c = c; e.ga = ga; e.lo = lo; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Monitor: pops expected items and compares at their cycle
    always @(negedge clk) begin
        exp_t it;
        while (q.size() > 0 && q[0].at <= cyc) begin
            it = q.pop_front();
            n_chk++;
            if (it.at != cyc || grant !== it.g || connect !== it.c ||
                gained !== it.ga || lost !== it.lo) begin
                n_fail++;
                $display("FAIL %s at cycle %0d (expected %0d): grant=%b exp %b connect=%b exp %b gained=%b exp %b lost=%b exp %b",
                         it.tag, cyc, it.at, grant, it.g, connect, it.c, gained, it.ga, lost, it.lo);
            end
        end
    end

    initial begin
        int k, m, n, p, r;
        repeat (3) step();
        rst = 1'b0;
        k = cyc;
        push(k + 1, 2'b00, 1'b0, 2'b00, 2'b00, "R8 reset state");

        // R1: tie on an idle bus, controller 0 first
        wait_cyc(k + 3);
        k = cyc;
        push(k + 1,  2'b01, 1'b1, 2'b01, 2'b00, "R1 tie to controller 0, R9 connect, R10 gained");
        push(k + 40, 2'b01, 1'b1, 2'b00, 2'b00, "R5 zero reserve keeps owner");
        req = 2'b11; step(); req = 2'b00;

        // R2 release handover, then R3/R4 with a 3-tick window for controller 1
        wait_cyc(k + 40);
        m = cyc;
        push(m + 1,  2'b00, 1'b0, 2'b00, 2'b00, "R2 one gap cycle, R10 no loss on release");
        push(m + 2,  2'b10, 1'b1, 2'b10, 2'b00, "R2 pending served");
        push(m + 10, 2'b10, 1'b1, 2'b00, 2'b00, "R3 window holds");
        push(m + 26, 2'b10, 1'b1, 2'b00, 2'b00, "R3 last protected cycle");
        push(m + 27, 2'b00, 1'b0, 2'b00, 2'b10, "R4 loss on expiry");
        push(m + 28, 2'b01, 1'b1, 2'b01, 2'b00, "R4 waiting controller granted");
        rel = 2'b01; step(); rel = 2'b00;
        step();
        req = 2'b01; step(); req = 2'b00;

        // R5: controller 0 owns with zero reserve, controller 1 waits
        wait_cyc(m + 30);
        n = cyc;
        resv1 = 8'd200;
        push(n + 60, 2'b01, 1'b1, 2'b00, 2'b00, "R5 no expiry without window");
        req = 2'b10; step(); req = 2'b00;

        // R6/R7: watchdog during a long window with a queued request
        wait_cyc(n + 60);
        push(n + 61,  2'b00, 1'b0, 2'b00, 2'b00, "R2 gap before second handover");
        push(n + 62,  2'b10, 1'b1, 2'b10, 2'b00, "R2 second handover");
        push(n + 880, 2'b10, 1'b1, 2'b00, 2'b00, "R7 strobe restarted count");
        push(n + 901, 2'b10, 1'b1, 2'b00, 2'b00, "R7 last quiet cycle");
        push(n + 902, 2'b00, 1'b0, 2'b00, 2'b10, "R6 watchdog disconnect");
        push(n + 904, 2'b00, 1'b0, 2'b00, 2'b00, "R6 pending cleared");
        rel = 2'b01; step(); rel = 2'b00;
        wait_cyc(n + 63);  wd_en = 1'b1;
        wait_cyc(n + 70);  bus_act = 1'b1; step(); bus_act = 1'b0;
        wait_cyc(n + 85);  bus_act = 1'b1; step(); bus_act = 1'b0;
        wait_cyc(n + 100); bus_act = 1'b1; step(); bus_act = 1'b0;
        wait_cyc(n + 500); req = 2'b01; step(); req = 2'b00;
        wait_cyc(n + 905); wd_en = 1'b0;

        // R8: software reset drops owner and queue
        p = cyc;
        push(p + 1, 2'b01, 1'b1, 2'b01, 2'b00, "R8 setup owner 0");
        req = 2'b01; step(); req = 2'b00;
        wait_cyc(p + 3);
        push(p + 6, 2'b00, 1'b0, 2'b00, 2'b00, "R8 soft reset clears owner");
        push(p + 8, 2'b00, 1'b0, 2'b00, 2'b00, "R8 soft reset clears queue");
        req = 2'b10; step(); req = 2'b00;
        wait_cyc(p + 5);
        soft_rst = 1'b1; step(); soft_rst = 1'b0;

        // R8: external reset
        wait_cyc(p + 10);
        r = cyc;
        push(r + 1, 2'b10, 1'b1, 2'b10, 2'b00, "R8 setup owner 1");
        push(r + 4, 2'b00, 1'b0, 2'b00, 2'b00, "R8 external reset clears owner");
        push(r + 6, 2'b00, 1'b0, 2'b00, 2'b00, "R8 external reset clears queue");
        req = 2'b10; step(); req = 2'b00;
        wait_cyc(r + 2); req = 2'b01; step(); req = 2'b00;
        wait_cyc(r + 3); ext_rst_n = 1'b0; step(); ext_rst_n = 1'b1;

        wait_cyc(r + 10);
        if (q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL R9 %0d expected items never compared, expected 0", q.size());
        end
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired at cycle %0d, expected end before 20000", cyc);
            summary();
            $finish;
        end
    end

endmodule